// File: doc/BRIEF.md
# Bit-flip fault injection sequencer

This block runs a fault injection campaign against one node of a time-triggered cluster. It takes injection targets one at a time from an upstream stream. Each target is a memory address of the node's host interface memory plus a data mask that should have exactly one bit set. For each valid target the block waits for the right point in the communication schedule. That point is the start of the slot that comes just before the node's own transmit slot, while the node is running its application. At that point the block issues one single-cycle transient bit-flip command, which the memory applies as an XOR of the mask.

After the flip, the sequencer watches the error-detection code bus. It stops at the first reported error, or after a fixed number of round-boundary pulses if no error is reported. It then emits one result record on a valid/ready handshake. Once the record is taken, it holds the node's restart line for a fixed number of cycles. It waits for the node to report ready before it accepts the next target. A target whose mask is not one-hot is never injected. Such a target produces a record with the reserved bad-mask code.

Top module: `fi_campaign_seq`

## Requirements
- R1: A target whose mask does not have exactly one bit set (zero bits or two or more) causes no flip command and no restart. It yields one record whose code is all ones (4'hF by default), and the next target is then accepted.
- R2: A flip command (`flip_valid_o` high, carrying the target's address and mask) is issued only in the cycle after a cycle in which `node_app_i`, `slot_start_i` and `own_slot_next_i` are all high while a valid target is armed. A slot start without the other two conditions issues nothing.
- R3: Each valid target produces exactly one flip command, and that command lasts one cycle.
- R4: The observation window opens in the cycle after the flip. The first `err_valid_i` inside the window ends it, and its `err_code_i` is recorded. Error strobes before the flip, or after the first error, do not affect the record.
- R5: If no error arrives, the window closes on the TIMEOUT_ROUNDS-th (default 4) `round_tick_i` after the flip, and the record carries code 0. After fewer ticks no record appears. An error in the same cycle as the closing tick takes precedence.
- R6: Each record carries the target address, the mask and the code. `res_valid_o` and the payload stay stable until `res_ready_i` is high.
- R7: After a record of an injected target is accepted, `node_rst_o` is high for exactly RST_CYCLES (default 8) consecutive cycles, starting in the next cycle. It is never high while a record is pending.
- R8: `tgt_ready_o` is high only while idle. After a restart, it rises only once `node_ready_i` is high.
- R9: After reset, `tgt_ready_o` is high and `flip_valid_o`, `res_valid_o` and `node_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tgt_valid_i | input | 1 | Target available |
| tgt_ready_o | output | 1 | Sequencer idle, target accepted |
| tgt_addr_i | input | ADDR_W | Target memory address |
| tgt_mask_i | input | DATA_W | Target bit mask |
| node_app_i | input | 1 | Node is in application state |
| slot_start_i | input | 1 | Start of a TDMA slot |
| own_slot_next_i | input | 1 | Next slot belongs to this node |
| round_tick_i | input | 1 | TDMA round boundary pulse |
| err_valid_i | input | 1 | Error detector report strobe |
| err_code_i | input | CODE_W | Detecting mechanism identity |
| flip_valid_o | output | 1 | One-cycle bit-flip command |
| flip_addr_o | output | ADDR_W | Address to corrupt |
| flip_mask_o | output | DATA_W | XOR mask to apply |
| node_rst_o | output | 1 | Node restart pulse |
| node_ready_i | input | 1 | Node back up after restart |
| res_valid_o | output | 1 | Result record valid |
| res_ready_i | input | 1 | Result record accepted |
| res_addr_o | output | ADDR_W | Recorded address |
| res_mask_o | output | DATA_W | Recorded mask |
| res_code_o | output | CODE_W | Recorded code (0 none, all ones bad mask) |

## Verification
Some properties are checked by assertions on every cycle. A flip is always one-hot and lasts one cycle, and it always follows a cycle with the schedule gate open. A pending record holds still under backpressure. A restart begins only right after a record is taken, and the round counter never passes its limit. Other behaviour can only be shown by the bench scenarios, because it depends on the exact sequence of events. These are: which error code wins when strobes arrive early, late or together with the last tick; that three round ticks are not enough to close the window; the exact restart length; the hold-off until the node is ready; and the skipping of zero and multi-bit masks.

// File: rtl/fi_seq_pkg.sv
package fi_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_INJECT, S_OBSERVE, S_REPORT, S_RESTART, S_WAIT_RDY
  } seq_state_e;
endpackage

// File: rtl/fi_mask_check.sv
module fi_mask_check #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] mask_i,
  output logic         one_hot_o
);
  logic [W-1:0] seen, dup;

  assign seen[0] = mask_i[0];
  assign dup[0]  = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_chain
    assign seen[i] = seen[i-1] | mask_i[i];
    assign dup[i]  = dup[i-1] | (seen[i-1] & mask_i[i]);
  end

  assign one_hot_o = seen[W-1] & ~dup[W-1];
endmodule

// File: rtl/fi_round_timer.sv
module fi_round_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_i)   cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

  assert_timer_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LIMIT));
endmodule

// File: rtl/fi_restart_gen.sv
module fi_restart_gen #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == CNT_W'(1));

  assert_no_retrigger_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_q == '0));
endmodule

// File: rtl/fi_campaign_seq.sv
module fi_campaign_seq
  import fi_seq_pkg::*;
#(
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned CODE_W         = 4,
  parameter int unsigned TIMEOUT_ROUNDS = 4,
  parameter int unsigned RST_CYCLES     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgt_valid_i,
  output logic              tgt_ready_o,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [DATA_W-1:0] tgt_mask_i,
  input  logic              node_app_i,
  input  logic              slot_start_i,
  input  logic              own_slot_next_i,
  input  logic              round_tick_i,
  input  logic              err_valid_i,
  input  logic [CODE_W-1:0] err_code_i,
  output logic              flip_valid_o,
  output logic [ADDR_W-1:0] flip_addr_o,
  output logic [DATA_W-1:0] flip_mask_o,
  output logic              node_rst_o,
  input  logic              node_ready_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic [DATA_W-1:0] res_mask_o,
  output logic [CODE_W-1:0] res_code_o
);
  localparam logic [CODE_W-1:0] CODE_NONE    = '0;
  localparam logic [CODE_W-1:0] CODE_BADMASK = '1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic [CODE_W-1:0] code_q, code_d;
  logic              skip_q;

  logic mask_ok, trigger, expire, rst_active, rst_last, accept_tgt, accept_res;

  fi_mask_check #(.W(DATA_W)) u_mask (
    .mask_i    (tgt_mask_i),
    .one_hot_o (mask_ok)
  );

  fi_round_timer #(.LIMIT(TIMEOUT_ROUNDS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == S_INJECT),
    .tick_i   ((state_q == S_OBSERVE) && round_tick_i),
    .expire_o (expire)
  );

  fi_restart_gen #(.CYCLES(RST_CYCLES)) u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept_res && !skip_q),
    .active_o (rst_active),
    .last_o   (rst_last)
  );

  assign trigger    = node_app_i && slot_start_i && own_slot_next_i;
  assign accept_tgt = (state_q == S_IDLE) && tgt_valid_i;
  assign accept_res = (state_q == S_REPORT) && res_ready_i;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    unique case (state_q)
      S_IDLE: if (tgt_valid_i) begin
        if (mask_ok) state_d = S_ARM;
        else begin
          state_d = S_REPORT;
          code_d  = CODE_BADMASK;
        end
      end
      S_ARM:     if (trigger) state_d = S_INJECT;
      S_INJECT:  state_d = S_OBSERVE;
      S_OBSERVE: begin
        if (err_valid_i) begin
          state_d = S_REPORT;
          code_d  = err_code_i;
        end else if (expire) begin
          state_d = S_REPORT;
          code_d  = CODE_NONE;
        end
      end
      S_REPORT:   if (res_ready_i) state_d = skip_q ? S_IDLE : S_RESTART;
      S_RESTART:  if (rst_last) state_d = S_WAIT_RDY;
      S_WAIT_RDY: if (node_ready_i) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      code_q  <= '0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      if (accept_tgt) begin
        addr_q <= tgt_addr_i;
        mask_q <= tgt_mask_i;
        skip_q <= !mask_ok;
      end
    end
  end

  assign tgt_ready_o  = (state_q == S_IDLE);
  assign flip_valid_o = (state_q == S_INJECT);
  assign flip_addr_o  = addr_q;
  assign flip_mask_o  = mask_q;
  assign node_rst_o   = rst_active;
  assign res_valid_o  = (state_q == S_REPORT);
  assign res_addr_o   = addr_q;
  assign res_mask_o   = mask_q;
  assign res_code_o   = code_q;

  assert_flip_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_valid_o |-> ($countones(flip_mask_o) == 1));

  assert_flip_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_valid_o |-> $past(node_app_i && slot_start_i && own_slot_next_i));

  assert_flip_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_valid_o |=> !flip_valid_o);

  assert_res_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_addr_o) && $stable(res_mask_o) && $stable(res_code_o)));

  assert_rst_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(node_rst_o) |-> $past(res_valid_o && res_ready_i));

  assert_rst_not_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !node_rst_o);

  assert_tgt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ready_o |-> (!node_rst_o && !res_valid_o && !flip_valid_o));
endmodule

// File: tb/sim_fi_campaign_seq.sv
`timescale 1ns/1ps
module sim_fi_campaign_seq;
  localparam int ADDR_W = 12, DATA_W = 16, CODE_W = 4, RST_CYC = 8;
  localparam int REC_W = ADDR_W + DATA_W + CODE_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tgt_valid = 1'b0, tgt_ready;
  logic [ADDR_W-1:0] tgt_addr = '0;
  logic [DATA_W-1:0] tgt_mask = '0;
  logic node_app = 1'b1, slot_start = 1'b0, own_next = 1'b0, rtick = 1'b0;
  logic err_valid = 1'b0;
  logic [CODE_W-1:0] err_code = '0;
  logic flip_valid, node_rst, res_valid;
  logic node_ready = 1'b1, res_ready = 1'b1;
  logic [ADDR_W-1:0] flip_addr, res_addr;
  logic [DATA_W-1:0] flip_mask, res_mask;
  logic [CODE_W-1:0] res_code;

  int n_chk = 0, n_fail = 0, n_flip = 0, n_rec = 0;
  bit done = 1'b0;
  logic [REC_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  fi_campaign_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tgt_valid_i(tgt_valid), .tgt_ready_o(tgt_ready),
    .tgt_addr_i(tgt_addr), .tgt_mask_i(tgt_mask),
    .node_app_i(node_app), .slot_start_i(slot_start), .own_slot_next_i(own_next),
    .round_tick_i(rtick), .err_valid_i(err_valid), .err_code_i(err_code),
    .flip_valid_o(flip_valid), .flip_addr_o(flip_addr), .flip_mask_o(flip_mask),
    .node_rst_o(node_rst), .node_ready_i(node_ready),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_addr_o(res_addr), .res_mask_o(res_mask), .res_code_o(res_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && flip_valid) n_flip++;
    if (rst_ni && res_valid && res_ready) begin
      logic [REC_W-1:0] got, want;
      got = {res_addr, res_mask, res_code};
      n_rec++;
      if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected record", 32'(got), 0);
      else begin
        want = exp_q.pop_front();
        chk(got == want, "R6", "record addr/mask", 32'({res_addr, res_mask}),
            32'(want[REC_W-1:CODE_W]));
        chk(res_code == want[CODE_W-1:0], "R4/R5", "record code", 32'(res_code),
            32'(want[CODE_W-1:0]));
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_target(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] m,
                             input logic [CODE_W-1:0] c);
    exp_q.push_back({a, m, c});
    @(posedge clk); #1;
    tgt_valid = 1'b1; tgt_addr = a; tgt_mask = m;
    do @(negedge clk); while (!tgt_ready);
    @(posedge clk); #1;
    tgt_valid = 1'b0;
  endtask

  task automatic fire_slot(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] m);
    @(posedge clk); #1; slot_start = 1'b1; own_next = 1'b1;
    @(posedge clk); #1; slot_start = 1'b0; own_next = 1'b0;
    @(negedge clk);
    chk(flip_valid == 1'b1, "R2", "flip issued at gate", 32'(flip_valid), 1);
    chk(flip_addr == a && flip_mask == m, "R2", "flip addr/mask",
        32'({flip_addr, flip_mask}), 32'({a, m}));
    @(negedge clk);
    chk(flip_valid == 1'b0, "R3", "flip lasts one cycle", 32'(flip_valid), 0);
  endtask

  task automatic tick();
    @(posedge clk); #1; rtick = 1'b1;
    @(posedge clk); #1; rtick = 1'b0;
  endtask

  task automatic err(input logic [CODE_W-1:0] c);
    @(posedge clk); #1; err_valid = 1'b1; err_code = c;
    @(posedge clk); #1; err_valid = 1'b0;
  endtask

  task automatic do_restart();
    int n;
    do @(negedge clk); while (!node_rst);
    node_ready = 1'b0;
    n = 1;
    forever begin
      @(negedge clk);
      if (node_rst) n++; else break;
    end
    chk(n == RST_CYC, "R7", "restart length", 32'(n), 32'(RST_CYC));
    cyc(3);
    chk(tgt_ready == 1'b0, "R8", "held off until node ready", 32'(tgt_ready), 0);
    node_ready = 1'b1;
    @(negedge clk);
    chk(tgt_ready == 1'b1, "R8", "idle after node ready", 32'(tgt_ready), 1);
  endtask

  initial begin
    cyc(3);
    chk(tgt_ready == 1'b1 && !flip_valid && !res_valid && !node_rst, "R9", "reset state",
        32'({tgt_ready, flip_valid, res_valid, node_rst}), 32'h8);
    @(posedge clk); #1; rst_ni = 1'b1;
    cyc(2);

    // experiment 1: gating, early error ignored, first error wins
    send_target(12'h123, 16'h0010, 4'h5);
    @(posedge clk); #1; slot_start = 1'b1; own_next = 1'b0;
    @(posedge clk); #1; slot_start = 1'b0;
    @(negedge clk);
    chk(flip_valid == 1'b0, "R2", "no flip without own-slot flag", 32'(flip_valid), 0);
    @(posedge clk); #1; node_app = 1'b0; slot_start = 1'b1; own_next = 1'b1;
    @(posedge clk); #1; node_app = 1'b1; slot_start = 1'b0; own_next = 1'b0;
    @(negedge clk);
    chk(flip_valid == 1'b0, "R2", "no flip outside app state", 32'(flip_valid), 0);
    err(4'h7); // R4: before injection, ignored
    fire_slot(12'h123, 16'h0010);
    tick(); tick();
    @(posedge clk); #1; err_valid = 1'b1; err_code = 4'h5;
    @(posedge clk); #1; err_code = 4'h6;
    @(posedge clk); #1; err_valid = 1'b0;
    do_restart();

    // experiment 2: timeout after four rounds
    send_target(12'h2A0, 16'h8000, 4'h0);
    fire_slot(12'h2A0, 16'h8000);
    tick(); tick(); tick();
    cyc(2);
    chk(res_valid == 1'b0, "R5", "no record after three rounds", 32'(res_valid), 0);
    tick();
    @(negedge clk);
    chk(res_valid == 1'b1, "R5", "record on fourth round", 32'(res_valid), 1);
    do_restart();

    // experiments 3 and 4: bad masks skipped
    send_target(12'h0F0, 16'h0003, 4'hF);
    send_target(12'h0F1, 16'h0000, 4'hF);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (flip_valid || node_rst)
        chk(1'b0, "R1", "bad mask flipped or restarted", 32'({flip_valid, node_rst}), 0);
    end
    chk(tgt_ready == 1'b1, "R1", "next target accepted after bad mask", 32'(tgt_ready), 1);

    // experiment 5: backpressure on the result
    @(posedge clk); #1; res_ready = 1'b0;
    send_target(12'h3FF, 16'h0001, 4'h9);
    fire_slot(12'h3FF, 16'h0001);
    err(4'h9);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(res_valid && !node_rst && res_code == 4'h9 && res_addr == 12'h3FF,
          "R6", "record held under backpressure", 32'({res_valid, node_rst, res_code}),
          32'({1'b1, 1'b0, 4'h9}));
    end
    @(posedge clk); #1; res_ready = 1'b1;
    do_restart();

    // experiment 6: error and closing tick in the same cycle
    send_target(12'h055, 16'h0400, 4'hC);
    fire_slot(12'h055, 16'h0400);
    tick(); tick(); tick();
    @(posedge clk); #1; rtick = 1'b1; err_valid = 1'b1; err_code = 4'hC;
    @(posedge clk); #1; rtick = 1'b0; err_valid = 1'b0;
    do_restart();

    cyc(4);
    chk(n_flip == 4, "R3", "one flip per valid target", 32'(n_flip), 4);
    chk(n_rec == 6 && exp_q.size() == 0, "R6", "all records seen", 32'(n_rec), 6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule